// File: doc/BRIEF.md
# Three-to-Two Phase Input Transform

This block takes one set of signed samples at a time and turns it into an orthogonal pair, a direct and a quadrature component, for a rotation stage further down the datapath. It also produces a zero-sequence value that shows whether a three-phase set is out of balance. A 2-bit format select chooses among three formats. The first is two inputs that are already orthogonal. The second is a full three-phase set at 0°, 120° and 240°. The third is a three-phase set where only phases B and C are supplied and phase A is rebuilt inside the block.

Each strobed sample set produces one registered result set on the next clock edge. The quadrature term scales the difference B − C by 1/√3. The block uses a fixed-point constant with FRAC fractional bits and clamps any result that falls outside the signed W-bit range.

Top module: `phase_xform_3to2`

## Requirements
- R1: While rst_n is low, out_d, out_q, out_zs and out_valid are all zero.
- R2: out_valid is high in the cycle after each clock edge that samples in_valid high, and low after each edge that samples it low.
- R3: With fmt = 2'b00 (orthogonal), out_d equals ph_a, out_q equals ph_b and out_zs is zero.
- R4: With fmt = 2'b01 (three inputs), out_d equals ph_a. out_q equals floor((ph_b − ph_c) · 37837 / 65536), which is the 1/√3 constant at 16 fractional bits with an arithmetic right shift, saturated.
- R5: With fmt = 2'b10 (two inputs), phase A is taken as −(ph_b + ph_c) and ph_a has no effect. out_d is that saturated value and out_q follows the same formula as R4.
- R6: out_zs equals (ph_a + ph_b + ph_c) / 3, truncated toward zero, in fmt 2'b01. It is zero in fmt 2'b00 and 2'b10.
- R7: fmt = 2'b11 gives exactly the results of fmt = 2'b01.
- R8: Any out_d or out_q result above 32767 reads 32767, and any result below −32768 reads −32768.
- R9: A clock edge with in_valid low leaves out_d, out_q and out_zs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample set strobe |
| fmt | input | 2 | Input format select |
| ph_a | input | W | Phase A / first orthogonal input, signed |
| ph_b | input | W | Phase B / second orthogonal input, signed |
| ph_c | input | W | Phase C, signed |
| out_d | output | W | Direct component, signed |
| out_q | output | W | Quadrature component, signed |
| out_zs | output | W | Zero-sequence value, signed |
| out_valid | output | 1 | Result strobe |

## Verification
Every result is due one clock edge after the edge that samples the strobe: out_d, out_q, out_zs and out_valid all come from a single register stage. The bench drives each sample set on a falling edge and compares the outputs on the next falling edge. That point lies half a period after the capturing rising edge. The hold case is checked the same way, after an edge with the strobe low and changed inputs.

// File: rtl/phase_xform_3to2.sv
module phase_xform_3to2 #(
  parameter int W    = 16,
  parameter int FRAC = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [1:0]          fmt,
  input  logic signed [W-1:0] ph_a,
  input  logic signed [W-1:0] ph_b,
  input  logic signed [W-1:0] ph_c,
  output logic signed [W-1:0] out_d,
  output logic signed [W-1:0] out_q,
  output logic signed [W-1:0] out_zs,
  output logic                out_valid
);
  localparam int KW = FRAC + 2;
  localparam int PW = W + 1 + KW;
  localparam logic signed [KW-1:0] KINV = KW'(((64'd1 << FRAC) * 64'd1000000000 + 64'd866025404) / 64'd1732050808);
  localparam logic signed [PW-1:0] HI = {{(PW-W+1){1'b0}}, {(W-1){1'b1}}};
  localparam logic signed [PW-1:0] LO = {{(PW-W+1){1'b1}}, {(W-1){1'b0}}};
  localparam logic signed [W+1:0] THREE = (W+2)'(3);

  function automatic logic signed [W-1:0] clamp(input logic signed [PW-1:0] v);
    if (v > HI) return HI[W-1:0];
    if (v < LO) return LO[W-1:0];
    return v[W-1:0];
  endfunction

  wire is_orth  = (fmt == 2'b00);
  wire is_recon = (fmt == 2'b10);

  logic signed [W+1:0] a_x, b_x, c_x, a_rec, sum3, zs_full;
  logic signed [W:0]   diff;
  logic signed [PW-1:0] diff_x, k_x, prod, q_full, d_full;
  logic signed [W-1:0] d_n, q_n, zs_n;

  assign a_x   = {{2{ph_a[W-1]}}, ph_a};
  assign b_x   = {{2{ph_b[W-1]}}, ph_b};
  assign c_x   = {{2{ph_c[W-1]}}, ph_c};
  assign a_rec = -(b_x + c_x);
  assign diff  = {ph_b[W-1], ph_b} - {ph_c[W-1], ph_c};

  assign diff_x = {{(PW-W-1){diff[W]}}, diff};
  assign k_x    = {{(PW-KW){1'b0}}, KINV};
  assign prod   = diff_x * k_x;
  assign q_full = prod >>> FRAC;
  assign d_full = is_recon ? {{(PW-W-2){a_rec[W+1]}}, a_rec} : {{(PW-W-2){a_x[W+1]}}, a_x};

  assign sum3    = a_x + b_x + c_x;
  assign zs_full = sum3 / THREE;

  assign d_n  = is_orth ? ph_a : clamp(d_full);
  assign q_n  = is_orth ? ph_b : clamp(q_full);
  assign zs_n = (is_orth || is_recon) ? '0 : zs_full[W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_d     <= '0;
      out_q     <= '0;
      out_zs    <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_d  <= d_n;
        out_q  <= q_n;
        out_zs <= zs_n;
      end
    end
  end
endmodule

// File: rtl/phase_xform_3to2_chk.sv
module phase_xform_3to2_chk #(
  parameter int W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic [1:0]          fmt,
  input logic signed [W-1:0] ph_a,
  input logic signed [W-1:0] ph_b,
  input logic signed [W-1:0] ph_c,
  input logic signed [W-1:0] out_d,
  input logic signed [W-1:0] out_q,
  input logic signed [W-1:0] out_zs,
  input logic                out_valid
);
  p_valid_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_orth_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fmt == 2'b00) |=> (out_d == $past(ph_a) && out_q == $past(ph_b)));
  p_three_direct_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fmt[0]) |=> out_d == $past(ph_a));
  p_zs_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fmt[0] == 1'b0) |=> out_zs == '0);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_d) && $stable(out_q) && $stable(out_zs)));
endmodule

bind phase_xform_3to2 phase_xform_3to2_chk #(.W(W)) u_chk (.*);

// File: tb/tb_phase_xform_3to2.sv
module tb_phase_xform_3to2;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [1:0] fmt = 2'b00;
  logic signed [15:0] ph_a = '0, ph_b = '0, ph_c = '0;
  logic signed [15:0] out_d, out_q, out_zs;
  logic out_valid;
  int n_chk = 0, n_bad = 0;
  longint kq;

  always #10 clk = ~clk;

  phase_xform_3to2 dut (.clk, .rst_n, .in_valid, .fmt, .ph_a, .ph_b, .ph_c,
                        .out_d, .out_q, .out_zs, .out_valid);

  task automatic chk(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint bsat(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  initial begin
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int vals[9] = '{-32768, -32767, -20000, -1, 0, 1, 3, 12345, 32767};
    kq = longint'(65536.0 / $sqrt(3.0));
    repeat (3) @(negedge clk);
    chk("R1 d", out_d, 0); chk("R1 q", out_q, 0);
    chk("R1 zs", out_zs, 0); chk("R1 valid", out_valid, 0);
    @(negedge clk); rst_n = 1'b1;

    for (int m = 0; m < 4; m++)
      for (int i = 0; i < 9; i++)
        for (int j = 0; j < 9; j++)
          for (int k = 0; k < 9; k++) begin
            longint a, b, c, ed, eq, ez, rd, rq;
            string td, tq, tz;
            a = vals[i]; b = vals[j]; c = vals[k];
            @(negedge clk);
            fmt = 2'(m); ph_a = 16'(a); ph_b = 16'(b); ph_c = 16'(c); in_valid = 1'b1;
            if (m == 0) begin
              rd = a; rq = b; ez = 0; td = "R3 d"; tq = "R3 q"; tz = "R6 zs";
            end else if (m == 2) begin
              rd = -(b + c); rq = ((b - c) * kq) >>> 16; ez = 0;
              td = "R5 d"; tq = "R5 q"; tz = "R6 zs";
            end else begin
              rd = a; rq = ((b - c) * kq) >>> 16; ez = (a + b + c) / 3;
              td = (m == 3) ? "R7 d" : "R4 d"; tq = (m == 3) ? "R7 q" : "R4 q";
              tz = (m == 3) ? "R7 zs" : "R6 zs";
            end
            ed = bsat(rd); eq = bsat(rq);
            if (ed != rd) td = "R8 d";
            if (eq != rq) tq = "R8 q";
            @(negedge clk);
            chk("R2 valid", out_valid, 1);
            chk(td, out_d, ed); chk(tq, out_q, eq); chk(tz, out_zs, ez);
          end

    @(negedge clk);
    fmt = 2'b01; ph_a = 16'sd100; ph_b = 16'sd200; ph_c = -16'sd50; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; ph_a = -16'sd7; ph_b = 16'sd9; ph_c = 16'sd1000;
    @(negedge clk);
    chk("R2 valid low", out_valid, 0);
    chk("R9 d", out_d, 100);
    chk("R9 q", out_q, (250 * kq) >>> 16);
    chk("R9 zs", out_zs, 83);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule